// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Sequencer

This block produces a slowly varying fractional offset that is added to the divider word of a fractional-N PLL to spread its output spectrum. The waveform is not stored as a table of full values. It is rebuilt at run time: the sequencer starts at a 6-bit base offset, adds twelve small unsigned deltas in turn, and then walks back down through the same deltas to the base. The result is a symmetric triangular profile that repeats.

The sequencer advances only on a phase-detector-rate enable. Each step is held for a programmable number of enabled cycles (the dwell), and a dwell of zero turns the function off. The offset word can be doubled before it leaves the block. A pseudo-random bit can also be XORed into its least significant bit, which adds dither ahead of the sigma-delta modulator that follows.

Configuration comes in on plain register inputs. The running sweep keeps a private copy of these inputs, and a new setting is taken up only when the walk has returned to the base, so a sweep is never spliced from two settings.

Top module: `ssm_profile_seq`

## Requirements
- R1: While `rst_n` is low, `offset_out` is 0. Reset leaves the running copy of the configuration all zero, so modulation is off.
- R2: While the running dwell is 0, `offset_out` is 0. On every `pfd_en` tick in that state the live inputs are copied, so a nonzero `cfg_dwell` starts a sweep at `cfg_base` on the next tick.
- R3: A sweep rises from the base through base+d0, base+d0+d1, and so on, up to the sum of the first N deltas. Delta k is `cfg_deltas[4k+3:4k]` and is unsigned. Each sample is held for `cfg_dwell` enabled ticks.
- R4: After the top sample the walk returns by subtracting the same deltas in reverse order until it reaches the base. The up-down sweep of 2N steps then repeats.
- R5: N equals `cfg_count`, clamped to 12 for values 13 to 15. With N = 0 the output holds at the base.
- R6: A change of the live inputs during a sweep has no effect until the walk arrives back at the base, where the whole new setting is taken, base included.
- R7: The accumulator never wraps. It holds the largest sum, 63 + 12×15 = 243.
- R8: With doubling set, `offset_out` is twice the sample value. With doubling clear, it is the sample value itself.
- R9: With dither set, the output LSB is XORed with a bit from a free-running 16-bit LFSR, refreshed on each `pfd_en` tick, so the output differs from the sample only in bit 0. With dither clear, the output is exact.
- R10: While `pfd_en` is low, `offset_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfd_en | input | 1 | Phase-detector-rate tick enable |
| cfg_base | input | 6 | Base offset, the first sample of each sweep |
| cfg_deltas | input | 48 | Twelve 4-bit unsigned deltas; delta k at bits 4k+3:4k |
| cfg_count | input | 4 | Number of deltas used (clamped to 12) |
| cfg_dwell | input | 4 | Enabled ticks per step; 0 turns modulation off |
| cfg_dither | input | 1 | LSB dither enable |
| cfg_double | input | 1 | Multiply output by two |
| offset_out | output | 9 | Offset word to the sigma-delta modulator |

## Verification
The assertions take the live inputs to be held between a setting and the sweep that uses it. They also take `pfd_en` to be the only source of progress, so that output stability with the enable low and evenness under doubling are properties of the state alone. The bench keeps to this: before each profile it pulses reset, it writes configuration only at falling edges, and it changes the inputs mid-sweep only in the test that checks deferred take-up. Dither is the one source of output not fixed by the requirements. It is checked as a bounded deviation in bit 0 plus evidence that the bit does toggle, never as an exact LFSR sequence.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/ssm_lfsr.sv
module ssm_lfsr #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  TAPS = 16'hB400,
    parameter logic [W-1:0]  SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    output logic noise_bit
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[W-2:0], ^(sr_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= SEED;
        else        sr_q <= sr_d;
    end

    assign noise_bit = sr_q[0];
endmodule

// File: rtl/ssm_stepper.sv
module ssm_stepper
    import ssm_pkg::*;
#(
    parameter int BASE_W = 6,
    parameter int DW     = 4,
    parameter int NDELTA = 12,
    parameter int CNT_W  = 4,
    parameter int DWL_W  = 4,
    parameter int ACC_W  = 8,
    parameter int IDX_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pfd_en,
    input  logic [BASE_W-1:0]      live_base,
    input  logic [NDELTA*DW-1:0]   live_deltas,
    input  logic [CNT_W-1:0]       live_count,
    input  logic [DWL_W-1:0]       live_dwell,
    input  logic                   live_dither,
    input  logic                   live_dbl,
    output logic [ACC_W-1:0]       run_acc,
    output logic [IDX_W-1:0]       run_idx,
    output logic                   run_off,
    output logic                   run_dither,
    output logic                   run_dbl
);
    typedef struct packed {
        logic [NDELTA*DW-1:0] deltas;
        logic [CNT_W-1:0]     count;
        logic [DWL_W-1:0]     dwell;
        logic                 dither;
        logic                 dbl;
        logic [ACC_W-1:0]     acc;
        logic [IDX_W-1:0]     idx;
        dir_e                 dir;
        logic [DWL_W-1:0]     cnt;
    } st_t;

    st_t s_d, s_q;
    int  n_eff;
    int  up_pos, dn_pos;
    logic [DW-1:0] delta_up, delta_dn;
    logic take;

    always_comb begin
        n_eff    = (int'(s_q.count) > NDELTA) ? NDELTA : int'(s_q.count);
        up_pos   = (int'(s_q.idx) < NDELTA) ? int'(s_q.idx) : 0;
        dn_pos   = (s_q.idx == '0) ? 0 : int'(s_q.idx) - 1;
        delta_up = s_q.deltas[up_pos*DW +: DW];
        delta_dn = s_q.deltas[dn_pos*DW +: DW];
        take     = 1'b0;
        s_d      = s_q;
        if (pfd_en) begin
            if (s_q.dwell == '0) begin
                take = 1'b1;
            end else if (s_q.cnt != s_q.dwell - DWL_W'(1)) begin
                s_d.cnt = s_q.cnt + DWL_W'(1);
            end else begin
                s_d.cnt = '0;
                if (n_eff == 0) begin
                    take = 1'b1;
                end else if (s_q.dir == DIR_UP) begin
                    s_d.acc = s_q.acc + ACC_W'(delta_up);
                    s_d.idx = s_q.idx + IDX_W'(1);
                    if (int'(s_q.idx) + 1 == n_eff) s_d.dir = DIR_DOWN;
                end else if (s_q.idx == IDX_W'(1)) begin
                    take = 1'b1;
                end else begin
                    s_d.acc = s_q.acc - ACC_W'(delta_dn);
                    s_d.idx = s_q.idx - IDX_W'(1);
                end
            end
        end
        if (take) begin
            s_d.deltas = live_deltas;
            s_d.count  = live_count;
            s_d.dwell  = live_dwell;
            s_d.dither = live_dither;
            s_d.dbl    = live_dbl;
            s_d.acc    = ACC_W'(live_base);
            s_d.idx    = '0;
            s_d.dir    = DIR_UP;
            s_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run_acc    = s_q.acc;
    assign run_idx    = s_q.idx;
    assign run_off    = (s_q.dwell == '0);
    assign run_dither = s_q.dither;
    assign run_dbl    = s_q.dbl;
endmodule

// File: rtl/ssm_out_stage.sv
module ssm_out_stage #(
    parameter int ACC_W = 8,
    parameter int OUT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfd_en,
    input  logic [ACC_W-1:0] run_acc,
    input  logic             run_off,
    input  logic             run_dither,
    input  logic             run_dbl,
    input  logic             noise_bit,
    output logic [OUT_W-1:0] offset_out
);
    typedef struct packed {
        logic dith;
    } os_t;

    os_t o_d, o_q;
    logic [ACC_W-1:0] value;

    always_comb begin
        o_d = o_q;
        if (pfd_en) o_d.dith = run_dither & noise_bit;
        value = run_acc ^ ACC_W'(o_q.dith & run_dither);
        if (run_off)      offset_out = '0;
        else if (run_dbl) offset_out = {value, 1'b0};
        else              offset_out = {1'b0, value};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end
endmodule

// File: rtl/ssm_profile_seq.sv
module ssm_profile_seq #(
    parameter int BASE_W = 6,
    parameter int DW     = 4,
    parameter int NDELTA = 12,
    parameter int CNT_W  = 4,
    parameter int DWL_W  = 4,
    parameter int LFSR_W = 16,
    localparam int ACC_MAX = (2**BASE_W - 1) + NDELTA * (2**DW - 1),
    localparam int ACC_W   = $clog2(ACC_MAX + 1),
    localparam int OUT_W   = ACC_W + 1,
    localparam int IDX_W   = $clog2(NDELTA + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pfd_en,
    input  logic [BASE_W-1:0]    cfg_base,
    input  logic [NDELTA*DW-1:0] cfg_deltas,
    input  logic [CNT_W-1:0]     cfg_count,
    input  logic [DWL_W-1:0]     cfg_dwell,
    input  logic                 cfg_dither,
    input  logic                 cfg_double,
    output logic [OUT_W-1:0]     offset_out
);
    logic [ACC_W-1:0] run_acc;
    logic [IDX_W-1:0] run_idx;
    logic             run_off, run_dither, run_dbl, noise_bit;

    ssm_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .noise_bit(noise_bit)
    );

    ssm_stepper #(
        .BASE_W(BASE_W), .DW(DW), .NDELTA(NDELTA), .CNT_W(CNT_W),
        .DWL_W(DWL_W), .ACC_W(ACC_W), .IDX_W(IDX_W)
    ) u_step (
        .clk(clk), .rst_n(rst_n), .pfd_en(pfd_en),
        .live_base(cfg_base), .live_deltas(cfg_deltas),
        .live_count(cfg_count), .live_dwell(cfg_dwell),
        .live_dither(cfg_dither), .live_dbl(cfg_double),
        .run_acc(run_acc), .run_idx(run_idx), .run_off(run_off),
        .run_dither(run_dither), .run_dbl(run_dbl)
    );

    ssm_out_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .pfd_en(pfd_en), .run_acc(run_acc),
        .run_off(run_off), .run_dither(run_dither), .run_dbl(run_dbl),
        .noise_bit(noise_bit), .offset_out(offset_out)
    );
endmodule

// File: rtl/ssm_profile_seq_chk.sv
module ssm_profile_seq_chk #(
    parameter int ACC_W   = 8,
    parameter int IDX_W   = 4,
    parameter int OUT_W   = 9,
    parameter int NDELTA  = 12,
    parameter int ACC_MAX = 243
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pfd_en,
    input logic [OUT_W-1:0] offset_out,
    input logic [ACC_W-1:0] acc,
    input logic [IDX_W-1:0] idx,
    input logic             run_off,
    input logic             run_dbl
);
    // R7
    acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc) <= ACC_MAX);

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx) <= NDELTA);

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pfd_en |=> $stable(offset_out));

    // R2
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_off |-> (offset_out == '0));

    // R8
    double_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_dbl && !run_off) |-> !offset_out[0]);
endmodule

bind ssm_profile_seq ssm_profile_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pfd_en(pfd_en), .offset_out(offset_out),
    .acc(run_acc), .idx(run_idx), .run_off(run_off), .run_dbl(run_dbl)
);

// File: tb/ssm_profile_seq_tb.sv
module ssm_profile_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfd_en = 1'b1;
    logic [5:0]  cfg_base = '0;
    logic [47:0] cfg_deltas = '0;
    logic [3:0]  cfg_count = '0;
    logic [3:0]  cfg_dwell = '0;
    logic        cfg_dither = 1'b0;
    logic        cfg_double = 1'b0;
    logic [8:0]  offset_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ssm_profile_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pfd_en(pfd_en), .cfg_base(cfg_base),
        .cfg_deltas(cfg_deltas), .cfg_count(cfg_count), .cfg_dwell(cfg_dwell),
        .cfg_dither(cfg_dither), .cfg_double(cfg_double), .offset_out(offset_out)
    );

    typedef struct packed {
        logic [5:0]  base;
        logic [47:0] dl;
        logic [3:0]  cnt;
        logic [3:0]  dw;
        logic        dbl;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        vec_t'{6'd10, 48'h000000000321, 4'd3,  4'd1,  1'b0},
        vec_t'{6'd63, 48'hFFFFFFFFFFFF, 4'd12, 4'd2,  1'b0},
        vec_t'{6'd5,  48'h123456789ABC, 4'd15, 4'd1,  1'b1},
        vec_t'{6'd20, 48'h0000000000F7, 4'd0,  4'd3,  1'b0},
        vec_t'{6'd0,  48'h000000000007, 4'd1,  4'd15, 1'b1}
    };

    function automatic int tri_val(int base, logic [47:0] dl, int cnt, int dw, bit dbl, int j);
        int n = (cnt > 12) ? 12 : cnt;
        int v = base;
        int p, m;
        if (n != 0) begin
            p = (j / dw) % (2 * n);
            m = (p <= n) ? p : 2 * n - p;
            for (int k = 0; k < m; k++) v += int'(dl[k*4 +: 4]);
        end
        return dbl ? 2 * v : v;
    endfunction

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Reset, load a setting during reset, release; the next falling edge is sample 0.
    task automatic start(vec_t v, bit dith);
        @(negedge clk);
        rst_n = 1'b0;
        pfd_en = 1'b1;
        cfg_base = v.base; cfg_deltas = v.dl; cfg_count = v.cnt;
        cfg_dwell = v.dw; cfg_double = v.dbl; cfg_dither = dith;
        @(negedge clk);
        chk("R1 reset output", int'(offset_out), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        vec_t a, b;
        int flips;
        // Table of profiles walked by one loop: R3 R4 R5 R7 R8
        for (int i = 0; i < NV; i++) begin
            start(VECS[i], 1'b0);
            for (int j = 0; j < 120; j++) begin
                @(negedge clk);
                chk($sformatf("R3 R4 R5 R7 R8 vec%0d s%0d", i, j), int'(offset_out),
                    tri_val(VECS[i].base, VECS[i].dl, VECS[i].cnt, VECS[i].dw, VECS[i].dbl, j));
            end
        end

        // R2: dwell zero forces zero, then a nonzero dwell starts at base next tick
        a = vec_t'{6'd40, 48'h000000000321, 4'd3, 4'd0, 1'b0};
        start(a, 1'b0);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            chk("R2 off output", int'(offset_out), 0);
        end
        cfg_dwell = 4'd1;
        @(negedge clk);
        chk("R2 start at base", int'(offset_out), 40);
        @(negedge clk);
        chk("R2 first step", int'(offset_out), 41);

        // R10: enable low holds the output, then the walk resumes
        a = vec_t'{6'd10, 48'h000000000321, 4'd3, 4'd1, 1'b0};
        start(a, 1'b0);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            chk("R10 pre-hold", int'(offset_out), tri_val(10, a.dl, 3, 1, 0, j));
        end
        pfd_en = 1'b0;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            chk("R10 hold", int'(offset_out), tri_val(10, a.dl, 3, 1, 0, 4));
        end
        pfd_en = 1'b1;
        for (int j = 5; j < 12; j++) begin
            @(negedge clk);
            chk("R10 resume", int'(offset_out), tri_val(10, a.dl, 3, 1, 0, j));
        end

        // R6: mid-sweep change waits for the return to base (period 12 samples)
        a = vec_t'{6'd10, 48'h000000000321, 4'd3, 4'd2, 1'b0};
        b = vec_t'{6'd30, 48'h000000000055, 4'd2, 4'd1, 1'b0};
        start(a, 1'b0);
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            if (j < 12)
                chk("R6 old sweep kept", int'(offset_out), tri_val(10, a.dl, 3, 2, 0, j));
            else
                chk("R6 new sweep taken", int'(offset_out), tri_val(30, b.dl, 2, 1, 0, j - 12));
            if (j == 4) begin
                cfg_base = b.base; cfg_deltas = b.dl; cfg_count = b.cnt; cfg_dwell = b.dw;
            end
        end

        // R9: dither only touches bit 0, and does toggle it
        a = vec_t'{6'd10, 48'h000000000021, 4'd2, 4'd1, 1'b0};
        start(a, 1'b1);
        flips = 0;
        for (int j = 0; j < 100; j++) begin
            int e;
            @(negedge clk);
            e = tri_val(10, a.dl, 2, 1, 0, j);
            chk("R9 dither bounded", int'(int'(offset_out) == e || int'(offset_out) == (e ^ 1)), 1);
            if (int'(offset_out) != e) flips++;
        end
        chk("R9 dither active", int'(flips > 0), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog R1-timeout: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule